// File: doc/BRIEF.md
# Normalized-Fraction Floating-Point Multiplier

This block multiplies two 32-bit floating-point words held in a custom format: one sign bit (0 positive, 1 negative) in bit 31, a 10-bit exponent field in bits 30:21 carrying the true exponent plus 512, and a 21-bit fraction in bits 20:0 that stores its leading one explicitly, so a normalized fraction `f` has value `f / 2^21` in the range [0.5, 1). A word whose fraction field is all zero is treated as the value zero. Nonzero operands are assumed to be normalized (bit 20 set).

A pulse on `start` while the block is idle captures both operands. The sign is the XOR of the operand signs, the true exponents are summed, and the two fractions are multiplied by a sequential shift-add unit, one partial product per cycle. Since both fractions lie in [0.5, 1), their product lies in [0.25, 1), so at most one left shift renormalizes it. The result word and the overflow and underflow flags are registered and announced by a one-cycle `done` pulse. They then hold until the next result.

The controller has three states. `S_IDLE` waits for `start` and moves to `S_MUL` when it arrives (transition *accept*). `S_MUL` stays put while the shift-add unit iterates and moves to `S_PACK` on the unit's finish pulse (transition *mul_finish*). `S_PACK` registers the packed result, raises `done` and returns to `S_IDLE` (transition *publish*).

Top module: `frac_float_mul`

## Requirements
- R1: The result sign bit (bit 31) is the XOR of the two operand sign bits for every nonzero result without a flag.
- R2: With true exponents Ea = field_a - 512 and Eb = field_b - 512, the result exponent field (bits 30:21) equals Ea + Eb + 512 when the 42-bit fraction product has bit 41 set, and Ea + Eb + 511 otherwise.
- R3: The result fraction (bits 20:0) is bits 41:21 of the 42-bit product of the two fraction fields when bit 41 is set, and bits 40:20 otherwise. The bits below are dropped by truncation, so every nonzero result has bit 20 set.
- R4: When the renormalized true exponent exceeds 511, `ovf` is 1, `unf` is 0 and the result word is all zero.
- R5: When the renormalized true exponent is below -512, `unf` is 1, `ovf` is 0 and the result word is all zero.
- R6: Renormalized true exponents of exactly 511 and exactly -512 give ordinary results with both flags clear.
- R7: If either operand's fraction field is zero, the result word is all zero and both flags are clear, whatever the signs and exponent fields.
- R8: `done` is high for exactly one cycle, in the cycle that follows the 23rd rising clock edge after the edge that accepted `start`. `product`, `ovf` and `unf` change only at that edge and hold their values otherwise.
- R9: `start` is ignored while a multiplication is in progress. The result still belongs to the operands that were accepted, and no extra `done` pulse appears.
- R10: While `rst_n` is low, `done`, `product`, `ovf` and `unf` are all zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; sampled only while idle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| done | output | 1 | One-cycle pulse when the result and flags are updated |
| product | output | 32 | Result word |
| ovf | output | 1 | Result exponent above the representable range |
| unf | output | 1 | Result exponent below the representable range |

## Verification
The bench aims at the exponent edges. It drives products whose renormalized exponent lands exactly on 511 and -512 and one step beyond each. An off-by-one in the bias or in the renormalization correction would then raise a flag on a legal result, or miss a flag on an illegal one. It mixes fraction pairs that need the one-bit left shift with pairs that do not, which catches a design that takes the wrong 21-bit slice or forgets to decrement the exponent. It also pairs zero operands with extreme exponent fields, where a design that checks the flags before testing for zero would report a spurious overflow, and it toggles `start` during a busy run, which would corrupt the result or add a second `done` pulse if it were not ignored.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W  = 10;
    localparam int FRAC_W = 21;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MUL  = 2'd1,
        S_PACK = 2'd2
    } fpm_state_t;

endpackage

// File: rtl/fpm_shift_add.sv
module fpm_shift_add #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W:0]   prod_hi,
    output logic         fin
);

    localparam int CW = $clog2(W + 1);

    logic [2*W-1:0] p_q;
    logic [W-1:0]   mcd_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic           fin_q;
    logic [W:0]     sum;

    // Add the multiplicand into the upper half when the current multiplier bit is set
    always_comb begin
        sum = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mcd_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q   <= '0;
            mcd_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                p_q   <= {{W{1'b0}}, mplier};
                mcd_q <= mcand;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                p_q <= {sum, p_q[W-1:1]};
                if (cnt_q == CW'(W - 1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign prod_hi = p_q[2*W-1:W-1];
    assign fin     = fin_q;

    AST_MUL_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q); // R8
    AST_MUL_FIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> !run_q); // R8

endmodule

// File: rtl/fpm_pack.sv
module fpm_pack #(
    parameter int EXP_W  = 10,
    parameter int FRAC_W = 21
) (
    input  logic                      sgn_a,
    input  logic                      sgn_b,
    input  logic [EXP_W-1:0]          ex_a,
    input  logic [EXP_W-1:0]          ex_b,
    input  logic [FRAC_W:0]           prod_hi,
    input  logic                      any_zero,
    output logic [EXP_W+FRAC_W:0]     word,
    output logic                      ovf,
    output logic                      unf
);

    localparam int BIAS = 1 << (EXP_W - 1);
    localparam int XW   = EXP_W + 2;
    localparam int EMAX = BIAS - 1;
    localparam int EMIN = -BIAS;

    logic                    lead;
    logic [FRAC_W-1:0]       frac;
    logic signed [XW-1:0]    e_true;
    logic [EXP_W-1:0]        exp_fld;
    logic                    hi;
    logic                    lo;

    always_comb begin
        lead    = prod_hi[FRAC_W];
        frac    = lead ? prod_hi[FRAC_W:1] : prod_hi[FRAC_W-1:0];
        e_true  = signed'(XW'(ex_a) + XW'(ex_b) - XW'(2 * BIAS) - XW'(!lead));
        exp_fld = EXP_W'(e_true + XW'(BIAS));
        hi      = int'(e_true) > EMAX;
        lo      = int'(e_true) < EMIN;
        if (any_zero) begin
            word = '0;
            ovf  = 1'b0;
            unf  = 1'b0;
        end else if (hi || lo) begin
            word = '0;
            ovf  = hi;
            unf  = lo;
        end else begin
            word = {sgn_a ^ sgn_b, exp_fld, frac};
            ovf  = 1'b0;
            unf  = 1'b0;
        end
    end

endmodule

// File: rtl/frac_float_mul.sv
module frac_float_mul
    import fpm_pkg::*;
#(
    parameter int EW = fpm_pkg::EXP_W,
    parameter int FW = fpm_pkg::FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [EW+FW:0]     op_a,
    input  logic [EW+FW:0]     op_b,
    output logic               done,
    output logic [EW+FW:0]     product,
    output logic               ovf,
    output logic               unf
);

    localparam int WW = 1 + EW + FW;

    fpm_state_t    state_q;
    fpm_state_t    state_d;
    logic [WW-1:0] a_q;
    logic [WW-1:0] b_q;
    logic          done_q;
    logic [WW-1:0] word_q;
    logic          ovf_q;
    logic          unf_q;

    logic          load;
    logic          mul_fin;
    logic [FW:0]   prod_hi;
    logic          any_zero;
    logic [WW-1:0] pk_word;
    logic          pk_ovf;
    logic          pk_unf;

    assign load     = (state_q == S_IDLE) && start;
    assign any_zero = (a_q[FW-1:0] == '0) || (b_q[FW-1:0] == '0);

    fpm_shift_add #(.W(FW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .mcand   (op_a[FW-1:0]),
        .mplier  (op_b[FW-1:0]),
        .prod_hi (prod_hi),
        .fin     (mul_fin)
    );

    fpm_pack #(.EXP_W(EW), .FRAC_W(FW)) u_pack (
        .sgn_a    (a_q[WW-1]),
        .sgn_b    (b_q[WW-1]),
        .ex_a     (a_q[WW-2:FW]),
        .ex_b     (b_q[WW-2:FW]),
        .prod_hi  (prod_hi),
        .any_zero (any_zero),
        .word     (pk_word),
        .ovf      (pk_ovf),
        .unf      (pk_unf)
    );

    // Next-state logic: accept, mul_finish, publish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)   state_d = S_MUL;
            S_MUL:   if (mul_fin) state_d = S_PACK;
            S_PACK:               state_d = S_IDLE;
            default:              state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand capture and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            done_q <= 1'b0;
            word_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                a_q <= op_a;
                b_q <= op_b;
            end
            if (state_q == S_PACK) begin
                done_q <= 1'b1;
                word_q <= pk_word;
                ovf_q  <= pk_ovf;
                unf_q  <= pk_unf;
            end
        end
    end

    assign done    = done_q;
    assign product = word_q;
    assign ovf     = ovf_q;
    assign unf     = unf_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> done_q); // R8
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q)); // R4
    AST_FLAG_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q || unf_q) |-> (word_q == '0)); // R5
    AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && word_q != '0) |-> word_q[FW-1]); // R3
    AST_HOLD_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(a_q) && $stable(b_q))); // R9

endmodule

// File: tb/tb_frac_float_mul.sv
module tb_frac_float_mul;

    localparam int CLK_PERIOD = 10;
    localparam int BIAS       = 512;
    localparam int LAT        = 23;
    localparam int N_RAND     = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic [31:0] product;
    logic        ovf;
    logic        unf;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";

    // Reference model state
    bit          m_busy = 0;
    int          m_left = 0;
    bit          m_done = 0;
    logic [31:0] m_word = '0;
    bit          m_ovf = 0;
    bit          m_unf = 0;
    logic [31:0] p_word = '0;
    bit          p_ovf = 0;
    bit          p_unf = 0;

    frac_float_mul dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .done    (done),
        .product (product),
        .ovf     (ovf),
        .unf     (unf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input bit s, input int ef, input int fr);
        return {s, 10'(ef), 21'(fr)};
    endfunction

    // Behavioural arithmetic model built from the requirements
    function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] w, output bit ov, output bit un);
        longint ma = longint'(a[20:0]);
        longint mb = longint'(b[20:0]);
        longint p;
        longint fr;
        int     adj;
        int     e;
        if (ma == 0 || mb == 0) begin
            w = '0; ov = 0; un = 0;
            return;
        end
        p = ma * mb;
        if (p >= (longint'(1) << 41)) begin
            fr = p >> 21; adj = 0;
        end else begin
            fr = (p >> 20) % (longint'(1) << 21); adj = 1;
        end
        e  = int'(a[30:21]) + int'(b[30:21]) - 2 * BIAS - adj;
        ov = e > BIAS - 1;
        un = e < -BIAS;
        if (ov || un) w = '0;
        else w = {a[31] ^ b[31], 10'(e + BIAS), 21'(fr)};
    endfunction

    // Cycle model: accept, count the fixed latency, publish
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_left = 0; m_done = 0;
            m_word = '0; m_ovf = 0; m_unf = 0;
        end else if (!m_busy && start) begin
            ref_mul(op_a, op_b, p_word, p_ovf, p_unf);
            m_busy = 1; m_left = LAT; m_done = 0;
        end else if (m_busy) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_busy = 0; m_done = 1;
                m_word = p_word; m_ovf = p_ovf; m_unf = p_unf;
            end else begin
                m_done = 0;
            end
        end else begin
            m_done = 0;
        end
    end

    // Compare every cycle away from the active edge (R8 timing, R10 reset)
    always @(negedge clk) begin
        n_chk++;
        if (done !== m_done) begin
            n_fail++;
            $display("FAIL R8 done: actual %0b expected %0b", done, m_done);
        end else if (product !== m_word || ovf !== m_ovf || unf !== m_unf) begin
            n_fail++;
            $display("FAIL %s: actual %h ovf=%0b unf=%0b expected %h ovf=%0b unf=%0b",
                     (!rst_n) ? "R10" : cur_req, product, ovf, unf, m_word, m_ovf, m_unf);
        end
    end

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        cur_req = req;
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    // R9: start pulses with other operands during a busy run
    task automatic run_busy_noise(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cur_req = "R9";
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            op_a = mk(k[0], 1000 - k, 21'h100000 | k);
            op_b = mk(1'b0, 1000, 21'h1FFFFF);
            start = (k % 3 == 0);
            @(negedge clk);
        end
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: hold reset a few cycles, checks run at each negedge
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: sign combinations
        run_op(mk(1, 512, 21'h100000), mk(0, 512, 21'h180000), "R1");
        run_op(mk(1, 520, 21'h155555), mk(1, 500, 21'h1ABCDE), "R1");
        run_op(mk(0, 530, 21'h1FFFFF), mk(1, 490, 21'h100001), "R1");
        // R2 R3: renormalization shift needed and not needed
        run_op(mk(0, 512, 21'h100000), mk(0, 512, 21'h100000), "R3");
        run_op(mk(0, 600, 21'h1FFFFF), mk(0, 400, 21'h1FFFFF), "R3");
        run_op(mk(0, 513, 21'h180000), mk(0, 511, 21'h180000), "R2");
        run_op(mk(0, 700, 21'h16A09E), mk(0, 300, 21'h16A09F), "R2");
        // R4: overflow
        run_op(mk(0, 1023, 21'h180000), mk(1, 1023, 21'h180000), "R4");
        run_op(mk(1, 1023, 21'h1FFFFF), mk(0, 513, 21'h1FFFFF), "R4");
        // R6: exponent exactly at both ends
        run_op(mk(1, 1023, 21'h1FFFFF), mk(0, 512, 21'h1FFFFF), "R6");
        run_op(mk(0, 0, 21'h1FFFFF), mk(0, 512, 21'h1FFFFF), "R6");
        run_op(mk(0, 0, 21'h100000), mk(0, 513, 21'h100000), "R6");
        // R5: underflow
        run_op(mk(0, 0, 21'h100000), mk(0, 512, 21'h100000), "R5");
        run_op(mk(1, 0, 21'h180000), mk(0, 0, 21'h180000), "R5");
        // R7: zero operands with extreme exponents
        run_op(mk(1, 1023, 0), mk(0, 1023, 21'h1FFFFF), "R7");
        run_op(mk(0, 5, 21'h123456), mk(1, 0, 0), "R7");
        run_op(mk(1, 0, 0), mk(1, 1023, 0), "R7");
        // R9: start ignored while busy
        run_busy_noise(mk(1, 515, 21'h1C0000), mk(0, 509, 21'h1A0000));
        run_busy_noise(mk(0, 1023, 21'h1FFFFF), mk(0, 1023, 21'h1FFFFF));
        // R2 R3: random normalized operands
        for (int i = 0; i < N_RAND; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = {1'($urandom), 10'($urandom), 1'b1, 20'($urandom)};
            rb = {1'($urandom), 10'($urandom), 1'b1, 20'($urandom)};
            run_op(ra, rb, "R2");
        end
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule